// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a chip. It is clocked by a test clock and steered by a mode-select line. It has a sixteen-state controller, an 8-bit instruction register and two data paths: a one-cell bypass path and a boundary chain placed around the chip's pads. The instruction that is loaded decides three things: which path sits between the serial input and the serial output, what a capture loads, and whether the pads carry the core's values, values from the chain's update latches, or nothing at all.

The boundary chain holds `BSR_LEN` cells (169 by default). It is split into three groups. The low `NPIN` cells control pad data, the next `NPIN` cells control pad output enables, and the remaining cells only observe pad inputs. Test equipment loads an instruction least significant bit first. It then scans the chosen data path and leaves it through the update state. Between scans the clock may run freely in Run-Test/Idle.

Top module: `scan_port`

## Requirements
- R1: While `trst_n` is low, the controller is held in Test-Logic-Reset, `ir_code` reads 0xFF, `tdo_oe` is 0, and the pads carry `core_do`/`core_oe`. This applies at once, with no clock edge needed.
- R2: Five rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset from any state. `ir_code` then reads 0xFF.
- R3: The instruction register is 8 bits and shifts towards bit 0, with `tdi` entering at bit 7. A full scan therefore leaves the first bit sent in bit 0. Capture-IR loads 0x01, so the first eight bits seen on `tdo` in Shift-IR are 1,0,0,0,0,0,0,0.
- R4: `ir_code` changes only on the falling edge of `tck` in Update-IR, or on entry to Test-Logic-Reset. It keeps its old value throughout an instruction scan.
- R5: Opcodes: 0x00 EXTEST, 0xC0 SAMPLE/PRELOAD, 0xF0 HIGHZ, 0xF1 CLAMP, 0xFF BYPASS. Every other code is reserved.
- R6: The bypass path is one cell. Capture-DR loads 0 into it, so a Shift-DR scan returns 0 first and then each `tdi` bit one clock late.
- R7: HIGHZ, CLAMP, BYPASS and every reserved opcode select the bypass path, and reserved opcodes drive the pads like BYPASS.
- R8: EXTEST and SAMPLE/PRELOAD select the boundary chain. Capture-DR loads `{pad_in, core_oe, core_do}` into cells [BSR_LEN-1:0], and cell 0 leaves first on `tdo`.
- R9: On the falling edge of `tck` in Update-DR with the chain selected, the update latches take the shifted contents. Under EXTEST and CLAMP, `pad_do` equals latches [NPIN-1:0] and `pad_oe` equals latches [2*NPIN-1:NPIN].
- R10: Under HIGHZ, `pad_oe` is all zero and `pad_do` follows `core_do`.
- R11: Under SAMPLE/PRELOAD, BYPASS and reserved codes, `pad_do`/`pad_oe` follow `core_do`/`core_oe`.
- R12: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is 1 exactly while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Drive enable for `tdo` |
| core_do | input | NPIN | Functional pad data from the core |
| core_oe | input | NPIN | Functional pad output enables from the core |
| pad_in | input | BSR_LEN-2*NPIN | Values observed on input-only pads |
| pad_do | output | NPIN | Data driven to the pads |
| pad_oe | output | NPIN | Output enables driven to the pads |
| ir_code | output | 8 | Active instruction code |

## Verification
The checker checks the following on every rising test clock. The five-ones return to reset is tracked with a run counter. `ir_code` may change only around Update-IR or reset. HIGHZ must keep every pad enable off. `tdo_oe` must agree with the shift states. Only the bench's scans can show some behaviours: the opcode map, the captured bit patterns and their order on `tdo`, the one-clock delay of the bypass cell, and the latch contents that reach the pads under EXTEST and CLAMP. The same holds for reserved codes behaving as BYPASS and for the CLAMP state left over from an earlier preload.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [3:0] {
    ST_TLR      = 4'd0,
    ST_RTI      = 4'd1,
    ST_SEL_DR   = 4'd2,
    ST_CAP_DR   = 4'd3,
    ST_SHF_DR   = 4'd4,
    ST_EX1_DR   = 4'd5,
    ST_PAU_DR   = 4'd6,
    ST_EX2_DR   = 4'd7,
    ST_UPD_DR   = 4'd8,
    ST_SEL_IR   = 4'd9,
    ST_CAP_IR   = 4'd10,
    ST_SHF_IR   = 4'd11,
    ST_EX1_IR   = 4'd12,
    ST_PAU_IR   = 4'd13,
    ST_EX2_IR   = 4'd14,
    ST_UPD_IR   = 4'd15
  } tap_state_e;

  typedef enum logic [2:0] {
    OP_EXTEST, OP_SAMPLE, OP_HIGHZ, OP_CLAMP, OP_BYPASS, OP_RSVD
  } op_e;

  localparam int unsigned IR_W = 8;
  localparam logic [IR_W-1:0] CODE_EXTEST = 8'h00;
  localparam logic [IR_W-1:0] CODE_SAMPLE = 8'hC0;
  localparam logic [IR_W-1:0] CODE_HIGHZ  = 8'hF0;
  localparam logic [IR_W-1:0] CODE_CLAMP  = 8'hF1;
  localparam logic [IR_W-1:0] CODE_BYPASS = 8'hFF;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 8'h01;

  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: return m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: return m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SHF_IR;
      default:   return m ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

  function automatic op_e op_decode(logic [IR_W-1:0] code);
    case (code)
      CODE_EXTEST: return OP_EXTEST;
      CODE_SAMPLE: return OP_SAMPLE;
      CODE_HIGHZ:  return OP_HIGHZ;
      CODE_CLAMP:  return OP_CLAMP;
      CODE_BYPASS: return OP_BYPASS;
      default:     return OP_RSVD;
    endcase
  endfunction

  function automatic logic op_uses_chain(op_e op);
    return (op == OP_EXTEST) || (op == OP_SAMPLE);
  endfunction

  function automatic logic op_drives_latches(op_e op);
    return (op == OP_EXTEST) || (op == OP_CLAMP);
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= tap_next(state, tms);
  end
endmodule

// File: rtl/ir_unit.sv
module ir_unit
  import scan_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            in_tlr,
  input  logic            capture_ir,
  input  logic            shift_ir,
  input  logic            update_ir,
  output logic [IR_W-1:0] ir_code,
  output logic            ir_lsb
);
  logic [IR_W-1:0] shf_q;
  logic [IR_W-1:0] act_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         shf_q <= IR_CAPTURE;
    else if (capture_ir) shf_q <= IR_CAPTURE;
    else if (shift_ir)   shf_q <= {tdi, shf_q[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)        act_q <= CODE_BYPASS;
    else if (in_tlr)    act_q <= CODE_BYPASS;
    else if (update_ir) act_q <= shf_q;
  end

  assign ir_code = in_tlr ? CODE_BYPASS : act_q;
  assign ir_lsb  = shf_q[0];
endmodule

// File: rtl/bsr_cell.sv
module bsr_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic cap_en,
  input  logic shf_en,
  input  logic upd_en,
  input  logic cap_d,
  input  logic ser_d,
  output logic ser_q,
  output logic upd_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     ser_q <= 1'b0;
    else if (cap_en) ser_q <= cap_d;
    else if (shf_en) ser_q <= ser_d;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     upd_q <= 1'b0;
    else if (upd_en) upd_q <= ser_q;
  end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain #(
  parameter int unsigned LEN = 169
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic           cap_en,
  input  logic           shf_en,
  input  logic           upd_en,
  input  logic           tdi,
  input  logic [LEN-1:0] cap_vec,
  output logic [LEN-1:0] upd_vec,
  output logic           chain_lsb
);
  logic [LEN:0]   link;
  logic [LEN-1:0] ser_q;

  assign link[LEN] = tdi;

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    bsr_cell u_cell (
      .tck    (tck),
      .trst_n (trst_n),
      .cap_en (cap_en),
      .shf_en (shf_en),
      .upd_en (upd_en),
      .cap_d  (cap_vec[i]),
      .ser_d  (link[i+1]),
      .ser_q  (ser_q[i]),
      .upd_q  (upd_vec[i])
    );
    assign link[i] = ser_q[i];
  end

  assign chain_lsb = link[0];
endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_pkg::*;
#(
  parameter int unsigned BSR_LEN = 169,
  parameter int unsigned NPIN    = 48,
  localparam int unsigned IN_W   = BSR_LEN - 2*NPIN
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  input  logic [NPIN-1:0] core_do,
  input  logic [NPIN-1:0] core_oe,
  input  logic [IN_W-1:0] pad_in,
  output logic [NPIN-1:0] pad_do,
  output logic [NPIN-1:0] pad_oe,
  output logic [IR_W-1:0] ir_code
);
  tap_state_e state;
  logic in_tlr, capture_ir, shift_ir, update_ir;
  logic capture_dr, shift_dr, update_dr;
  logic ir_lsb, chain_lsb, byp_q;
  logic sel_chain, drive_latch, force_off;
  op_e  op;
  logic [BSR_LEN-1:0] upd_vec;

  tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  assign in_tlr     = (state == ST_TLR);
  assign capture_ir = (state == ST_CAP_IR);
  assign shift_ir   = (state == ST_SHF_IR);
  assign update_ir  = (state == ST_UPD_IR);
  assign capture_dr = (state == ST_CAP_DR);
  assign shift_dr   = (state == ST_SHF_DR);
  assign update_dr  = (state == ST_UPD_DR);

  ir_unit u_ir (
    .tck        (tck),
    .trst_n     (trst_n),
    .tdi        (tdi),
    .in_tlr     (in_tlr),
    .capture_ir (capture_ir),
    .shift_ir   (shift_ir),
    .update_ir  (update_ir),
    .ir_code    (ir_code),
    .ir_lsb     (ir_lsb)
  );

  assign op          = op_decode(ir_code);
  assign sel_chain   = op_uses_chain(op);
  assign drive_latch = op_drives_latches(op);
  assign force_off   = (op == OP_HIGHZ);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                       byp_q <= 1'b0;
    else if (capture_dr && !sel_chain) byp_q <= 1'b0;
    else if (shift_dr && !sel_chain)   byp_q <= tdi;
  end

  bsr_chain #(.LEN(BSR_LEN)) u_chain (
    .tck       (tck),
    .trst_n    (trst_n),
    .cap_en    (capture_dr && sel_chain),
    .shf_en    (shift_dr && sel_chain),
    .upd_en    (update_dr && sel_chain),
    .tdi       (tdi),
    .cap_vec   ({pad_in, core_oe, core_do}),
    .upd_vec   (upd_vec),
    .chain_lsb (chain_lsb)
  );

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shift_ir || shift_dr;
      if (shift_ir)       tdo <= ir_lsb;
      else if (sel_chain) tdo <= chain_lsb;
      else                tdo <= byp_q;
    end
  end

  always_comb begin
    pad_do = core_do;
    pad_oe = core_oe;
    if (drive_latch) begin
      pad_do = upd_vec[NPIN-1:0];
      pad_oe = upd_vec[2*NPIN-1:NPIN];
    end else if (force_off) begin
      pad_oe = '0;
    end
  end
endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk #(
  parameter int unsigned NPIN = 48
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input logic            in_tlr,
  input logic            shift_ir,
  input logic            shift_dr,
  input logic            update_ir,
  input logic            tdo_oe,
  input logic [7:0]      ir_code,
  input logic [NPIN-1:0] pad_oe
);
  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          ones_cnt <= '0;
    else if (!tms)        ones_cnt <= '0;
    else if (ones_cnt < 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  // R1
  trst_bypass_chk: assert property (@(posedge tck) !trst_n |-> ir_code == 8'hFF);

  // R2
  five_ones_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt >= 3'd4 && tms) |=> in_tlr);

  // R4
  ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(ir_code) |-> (update_ir || in_tlr));

  // R10
  highz_off_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_code == 8'hF0) |-> (pad_oe == '0));

  // R12
  tdo_oe_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (shift_ir || shift_dr));
endmodule

bind scan_port scan_port_chk #(.NPIN(NPIN)) u_chk (
  .tck       (tck),
  .trst_n    (trst_n),
  .tms       (tms),
  .in_tlr    (in_tlr),
  .shift_ir  (shift_ir),
  .shift_dr  (shift_dr),
  .update_ir (update_ir),
  .tdo_oe    (tdo_oe),
  .ir_code   (ir_code),
  .pad_oe    (pad_oe)
);

// File: tb/scan_port_tb.sv
module scan_port_tb;
  localparam int BL = 169;
  localparam int NP = 48;
  localparam int IW = BL - 2*NP;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe;
  logic [NP-1:0] core_do = 48'hA5C3_1F0E_9B27;
  logic [NP-1:0] core_oe = 48'h0FF0_33CC_5A5A;
  logic [IW-1:0] pad_in  = 73'h1_2345_6789_ABCD_EF01;
  logic [NP-1:0] pad_do, pad_oe;
  logic [7:0] ir_code;

  int compared = 0, mismatched = 0;

  always #5 tck = ~tck;

  scan_port u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .core_do(core_do), .core_oe(core_oe), .pad_in(pad_in),
    .pad_do(pad_do), .pad_oe(pad_oe), .ir_code(ir_code)
  );

  // opcode[10:3], chain selected[2], pad mode[1:0]: 0 core, 1 latches, 2 all off
  localparam logic [10:0] VEC [8] = '{
    {8'hC0, 1'b1, 2'd0}, {8'hF1, 1'b0, 2'd1}, {8'h00, 1'b1, 2'd1},
    {8'hF0, 1'b0, 2'd2}, {8'hFF, 1'b0, 2'd0}, {8'h01, 1'b0, 2'd0},
    {8'h80, 1'b0, 2'd0}, {8'hC1, 1'b0, 2'd0}
  };

  task automatic chk(input string req, input logic [BL-1:0] act, input logic [BL-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o, output logic oe);
    @(negedge tck); #1;
    o = tdo; oe = tdo_oe;
    tms = m; tdi = d;
  endtask

  task automatic step(input logic m);
    logic o, oe;
    tick(m, 1'b0, o, oe);
  endtask

  task automatic scan_ir(input logic [7:0] code, output logic [7:0] cap);
    logic o, oe, oe_all;
    logic [7:0] old;
    old = ir_code;
    oe_all = 1'b1;
    step(1); step(1); step(0); step(0);
    for (int i = 0; i < 8; i++) begin
      tick(i == 7, code[i], o, oe);
      cap[i] = o;
      oe_all = oe_all & oe;
    end
    chk("R12 tdo_oe in Shift-IR", {168'd0, oe_all}, {168'd0, 1'b1});
    step(1);
    chk("R4 ir held during scan", {161'd0, ir_code}, {161'd0, old});
    step(0);
  endtask

  task automatic scan_dr(input logic [BL-1:0] din, output logic [BL-1:0] dout);
    logic o, oe;
    step(1); step(0); step(0);
    for (int i = 0; i < BL; i++) begin
      tick(i == BL-1, din[i], o, oe);
      dout[i] = o;
    end
    step(1); step(0); step(0);
  endtask

  function automatic logic [BL-1:0] pat(int s);
    logic [BL-1:0] p;
    for (int j = 0; j < BL; j++) p[j] = ((j*5 + s*3) % 7) < 3;
    return p;
  endfunction

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] capir;
    logic [BL-1:0] din, dout, capv, latch_model, expo;
    logic o, oe;
    latch_model = '0;
    capv = {pad_in, core_oe, core_do};

    // R1: reset state
    #23;
    chk("R1 ir_code in reset", {161'd0, ir_code}, {161'd0, 8'hFF});
    chk("R1 tdo_oe in reset", {168'd0, tdo_oe}, '0);
    chk("R1 pads follow core", {73'd0, pad_oe, pad_do}, {73'd0, core_oe, core_do});
    @(negedge tck); #1; trst_n = 1'b1; tms = 1'b1;
    step(0); step(0);
    tick(0, 0, o, oe);
    chk("R12 tdo_oe idle", {168'd0, oe}, '0);

    foreach (VEC[k]) begin
      logic [7:0] op;
      op = VEC[k][10:3];
      scan_ir(op, capir);
      chk("R3 capture-IR pattern", {161'd0, capir}, {161'd0, 8'h01});
      chk("R5 opcode loaded", {161'd0, ir_code}, {161'd0, op});
      din = pat(k);
      scan_dr(din, dout);
      if (VEC[k][2]) begin
        chk("R8 chain captures and shifts", dout, capv);
        latch_model = din;
      end else begin
        expo = {din[BL-2:0], 1'b0};
        chk("R6 R7 bypass one cell", dout, expo);
      end
      case (VEC[k][1:0])
        2'd1: chk("R9 pads from latches", {73'd0, pad_oe, pad_do},
                  {73'd0, latch_model[2*NP-1:NP], latch_model[NP-1:0]});
        2'd2: chk("R10 highz pads", {73'd0, pad_oe, pad_do}, {73'd0, {NP{1'b0}}, core_do});
        default: chk("R11 pads follow core", {73'd0, pad_oe, pad_do}, {73'd0, core_oe, core_do});
      endcase
    end

    // R2: from Shift-DR under HIGHZ, five ones reach Test-Logic-Reset
    scan_ir(8'hF0, capir);
    step(1); step(0); step(0);
    for (int i = 0; i < 5; i++) step(1);
    step(1);
    chk("R2 five ones to reset", {161'd0, ir_code}, {161'd0, 8'hFF});
    chk("R2 pads back to core", {73'd0, pad_oe, pad_do}, {73'd0, core_oe, core_do});

    // R1: asynchronous reset mid-operation
    step(0);
    scan_ir(8'h00, capir);
    #2; trst_n = 1'b0; #1;
    chk("R1 async reset ir_code", {161'd0, ir_code}, {161'd0, 8'hFF});
    chk("R1 async reset pads", {73'd0, pad_oe, pad_do}, {73'd0, core_oe, core_do});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule